// File: doc/BRIEF.md
# Multiplexed External Bus Strobe Generator

This block sequences one 8-bit external memory bus for a small microcontroller. It produces the address-latch strobe and the active-low program-store enable. It also decides what the shared 8-bit port carries on each tick: the low address byte, write data, or nothing while a read comes back. It runs on a tick at twice the oscillator rate. One bus frame is eight ticks, which is four oscillator periods.

The bus mode comes from a pin and is latched only while power-on reset is held. A low pin selects multiplexed mode. A high pin selects demultiplexed mode. In multiplexed mode the address byte rides the port while the strobe is high, and the port becomes the data bus once the strobe falls. In demultiplexed mode the port only carries data. The strobe then keeps running as a free clock, unless a latch-disable control bit parks it high.

Fetch requests are sampled at frame boundaries. During a fetch frame the program-store enable pulses low after the strobe falls. The port input is captured as read data on the last tick of that frame.

Top module: `ext_bus_strobe`

## Requirements
- R1: A frame is 8 ticks, phases 0 to 7. Outside reset, and unless R6 parks it, the strobe `ale` is high on phases 0, 1 and 2 and low on phases 3 to 7, which is 1.5 of 4 oscillator periods.
- R2: `demuxMode` takes the value of `modePin` only while `porRst` is high (1 = demultiplexed, 0 = multiplexed). Changes on `modePin` at any other time, including during `coreRst`, have no effect.
- R3: In multiplexed mode the port drives `portOe`=1 with the registered low address byte on phases 0 to 2 of every frame that is not a fetch. On phases 3 to 7 it drives the registered write data.
- R4: In demultiplexed mode the port never presents address. In a frame that is not a fetch it drives the registered write data with `portOe`=1 on all 8 phases.
- R5: While `porRst` or `coreRst` is high, `ale` is 1 and `psenN` is 1.
- R6: In demultiplexed mode with `latchOff`=1, `ale` stays 1. In multiplexed mode `latchOff` has no effect on `ale`.
- R7: `psenN` is 0 on phases 4 to 7 of a fetch frame and 1 at every other time.
- R8: `fetchReq`, `fetchAddr[7:0]` and `wrData` are sampled at the clock edge that ends phase 7 (or ends reset) and apply to the following frame. A frame that follows reset is never a fetch, and its address and write data are zero.
- R9: In a fetch frame `portOe` is 0 on phases 3 to 7 in multiplexed mode, and on all phases in demultiplexed mode. `rdData` loads `portIn` at the edge that ends phase 7 of a fetch frame and holds its value at all other times.
- R10: While `porRst` or `coreRst` is high, `portOut` is 8'hFF and `portOe` is 1. `rdData` clears to 0. Phase 0 is the first tick after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the oscillator rate |
| porRst | input | 1 | Power-on reset, active high; also opens the mode latch |
| coreRst | input | 1 | Core reset, active high |
| modePin | input | 1 | Bus mode pin, 1 = demultiplexed |
| latchOff | input | 1 | Strobe park bit for demultiplexed mode |
| fetchReq | input | 1 | Request an external fetch in the next frame |
| fetchAddr | input | 16 | Fetch address; only the low byte reaches the port |
| wrData | input | 8 | Data driven in the data phase of frames that are not fetches |
| portIn | input | 8 | Value read back from the shared port |
| ale | output | 1 | Address-latch strobe |
| psenN | output | 1 | Program-store enable, active low |
| portOut | output | 8 | Shared port output value |
| portOe | output | 1 | Shared port output enable |
| rdData | output | 8 | Last byte captured in a fetch |

## Verification
The bench runs long stretches of seeded random fetch requests, addresses, write data, port input and `latchOff` changes in each bus mode. Mixing fetch and non-fetch frames shows whether the enable pulse and the read capture track the frame in which the request was sampled, rather than the current request. Random `modePin` changes outside power-on reset, plus short `coreRst` pulses, show whether the mode latch is truly frozen and whether the frame restarts at phase 0. Toggling `latchOff` in both modes shows that parking applies only in demultiplexed mode.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef struct packed {
    logic rstHold;    // block is in reset: force the port to ones
    logic addrPhase;  // present the low address byte
    logic drive;      // port output enable
    logic loadFrame;  // frame boundary: take new address and write data
    logic capture;    // last tick of a fetch: take the read byte
  } strobe_t;
endpackage

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int FRAME_TICKS  = 8,
  parameter int STROBE_TICKS = 3
) (
  input  logic clk,
  input  logic porRst,
  input  logic coreRst,
  input  logic modePin,
  input  logic latchOff,
  input  logic fetchReq,
  output logic ale,
  output logic psenN,
  output ext_bus_pkg::strobe_t strobes
);
  localparam int PHASE_W = $clog2(FRAME_TICKS);
  localparam int RUN_W   = $clog2(FRAME_TICKS + 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(FRAME_TICKS - 1);
  localparam logic [PHASE_W-1:0] STROBE_END = PHASE_W'(STROBE_TICKS);
  localparam logic [RUN_W-1:0]   RUN_MAX    = RUN_W'(FRAME_TICKS);
  localparam logic [RUN_W-1:0]   RUN_LIMIT  = RUN_W'(STROBE_TICKS);

  logic inReset;
  logic demuxMode;
  logic actFetch;
  logic [PHASE_W-1:0] phase;
  logic frameEnd;
  logic strobeWin;

  assign inReset   = porRst | coreRst;
  assign frameEnd  = (phase == LAST_PHASE);
  assign strobeWin = (phase < STROBE_END);

  // mode latch: open only during power-on reset
  always_ff @(posedge clk) begin
    if (porRst) demuxMode <= modePin;
  end

  always_ff @(posedge clk) begin
    if (inReset) begin
      phase    <= '0;
      actFetch <= 1'b0;
    end else if (frameEnd) begin
      phase    <= '0;
      actFetch <= fetchReq;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign ale   = inReset | (demuxMode & latchOff) | strobeWin;
  assign psenN = ~(~inReset & actFetch & (phase > STROBE_END));

  always_comb begin
    strobes.rstHold   = inReset;
    strobes.addrPhase = ~inReset & ~demuxMode & strobeWin;
    strobes.drive     = inReset | ~(actFetch & (demuxMode | ~strobeWin));
    strobes.loadFrame = ~inReset & frameEnd;
    strobes.capture   = ~inReset & frameEnd & actFetch;
  end

  // checker state: length of the current strobe-high run in multiplexed mode
  logic [RUN_W-1:0] aleRun;
  always_ff @(posedge clk) begin
    if (inReset || demuxMode || !ale) aleRun <= '0;
    else if (aleRun != RUN_MAX)       aleRun <= aleRun + 1'b1;
  end

  assert_strobe_width_R1: assert property (@(posedge clk) disable iff (inReset)
    aleRun <= RUN_LIMIT);
  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (porRst)
    !$past(porRst) |-> $stable(demuxMode));
  assert_reset_strobe_R5: assert property (@(posedge clk)
    inReset |-> (ale && psenN));
  assert_enable_clear_of_strobe_R7: assert property (@(posedge clk) disable iff (inReset)
    (!psenN && !demuxMode) |-> !ale);
endmodule

// File: rtl/ext_bus_data.sv
module ext_bus_data #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  ext_bus_pkg::strobe_t strobes,
  input  logic [DATA_W-1:0] addrLowIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] portOut,
  output logic portOe,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;

  always_ff @(posedge clk) begin
    if (strobes.rstHold) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdData  <= '0;
    end else begin
      if (strobes.loadFrame) begin
        addrReg <= addrLowIn;
        wrReg   <= wrData;
      end
      if (strobes.capture) rdData <= portIn;
    end
  end

  always_comb begin
    if (strobes.rstHold)        portOut = '1;
    else if (strobes.addrPhase) portOut = addrReg;
    else                        portOut = wrReg;
  end
  assign portOe = strobes.drive;

  assert_no_drive_on_capture_R9: assert property (@(posedge clk) disable iff (strobes.rstHold)
    strobes.capture |-> !portOe);
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (strobes.rstHold)
    !$past(strobes.capture) && !$past(strobes.rstHold) |-> $stable(rdData));
  assert_reset_ones_R10: assert property (@(posedge clk)
    strobes.rstHold |-> (portOut == '1 && portOe));
endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int FRAME_TICKS  = 8,
  parameter int STROBE_TICKS = 3
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              coreRst,
  input  logic              modePin,
  input  logic              latchOff,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] portIn,
  output logic              ale,
  output logic              psenN,
  output logic [DATA_W-1:0] portOut,
  output logic              portOe,
  output logic [DATA_W-1:0] rdData
);
  ext_bus_pkg::strobe_t strobes;
  logic unusedAddrHigh;
  assign unusedAddrHigh = ^fetchAddr[ADDR_W-1:DATA_W];

  ext_bus_ctrl #(.FRAME_TICKS(FRAME_TICKS), .STROBE_TICKS(STROBE_TICKS)) ctrl (
    .clk(clk), .porRst(porRst), .coreRst(coreRst), .modePin(modePin),
    .latchOff(latchOff), .fetchReq(fetchReq), .ale(ale), .psenN(psenN),
    .strobes(strobes)
  );

  ext_bus_data #(.DATA_W(DATA_W)) data (
    .clk(clk), .strobes(strobes), .addrLowIn(fetchAddr[DATA_W-1:0]),
    .wrData(wrData), .portIn(portIn), .portOut(portOut), .portOe(portOe),
    .rdData(rdData)
  );
endmodule

// File: tb/ext_bus_strobe_test.sv
module ext_bus_strobe_test;
  logic clk = 1'b0;
  logic porRst = 1'b1, coreRst = 1'b0, modePin = 1'b0, latchOff = 1'b0, fetchReq = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic [7:0]  wrData = '0, portIn = '0;
  logic ale, psenN, portOe;
  logic [7:0] portOut, rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the requirements
  int mPhase = 0;
  bit mFetch = 0, mMode = 0;
  logic [7:0] mAddr = '0, mWr = '0, mRd = '0;

  always #5 clk = ~clk;

  ext_bus_strobe uut (
    .clk(clk), .porRst(porRst), .coreRst(coreRst), .modePin(modePin),
    .latchOff(latchOff), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .wrData(wrData), .portIn(portIn), .ale(ale), .psenN(psenN),
    .portOut(portOut), .portOe(portOe), .rdData(rdData)
  );

  function automatic bit expAle(bit rst, bit dm, bit off, int ph);
    return rst || (dm && off) || (ph < 3);
  endfunction
  function automatic bit expPsen(bit rst, bit f, int ph);
    return !(!rst && f && ph >= 4);
  endfunction
  function automatic bit expOe(bit rst, bit f, bit dm, int ph);
    return rst || !(f && (dm || ph >= 3));
  endfunction
  function automatic logic [7:0] expPort(bit rst, bit dm, int ph, logic [7:0] a, logic [7:0] w);
    if (rst) return 8'hFF;
    if (!dm && ph < 3) return a;
    return w;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (phase %0d)", req, act, exp, mPhase);
    end
  endtask

  task automatic checkAll();
    bit rst = porRst || coreRst;
    string t;
    if (rst) t = "R5"; else if (mMode && latchOff) t = "R6"; else t = "R1";
    check(t, 8'(ale), 8'(expAle(rst, mMode, latchOff, mPhase)));
    check(rst ? "R5" : "R7", 8'(psenN), 8'(expPsen(rst, mFetch, mPhase)));
    check(rst ? "R10" : "R9", 8'(portOe), 8'(expOe(rst, mFetch, mMode, mPhase)));
    if (expOe(rst, mFetch, mMode, mPhase)) begin
      if (rst) t = "R10";
      else if (modePin != mMode) t = "R2";
      else if (!mMode && mPhase < 3) t = "R8";
      else if (mMode) t = "R4";
      else t = "R3";
      check(t, portOut, expPort(rst, mMode, mPhase, mAddr, mWr));
    end
    check(rst ? "R10" : "R9", rdData, mRd);
  endtask

  // advance the model across the next rising edge, using the inputs now applied
  task automatic stepModel();
    bit rst = porRst || coreRst;
    if (porRst) mMode = modePin;
    if (rst) begin
      mPhase = 0; mFetch = 0; mAddr = '0; mWr = '0; mRd = '0;
    end else if (mPhase == 7) begin
      if (mFetch) mRd = portIn;
      mFetch = fetchReq; mAddr = fetchAddr[7:0]; mWr = wrData; mPhase = 0;
    end else begin
      mPhase++;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    checkAll();
  endtask

  task automatic applyAndStep();
    stepModel();
  endtask

  task automatic randomRun(int n, bit allowCore);
    for (int i = 0; i < n; i++) begin
      cycle();
      fetchReq  = $urandom_range(1, 0);
      fetchAddr = 16'($urandom);
      wrData    = 8'($urandom);
      portIn    = 8'($urandom);
      modePin   = $urandom_range(1, 0);
      if ($urandom_range(15, 0) == 0) latchOff = ~latchOff;
      coreRst   = allowCore && ($urandom_range(63, 0) == 0);
      applyAndStep();
    end
  endtask

  task automatic powerOn(bit mode);
    cycle();
    porRst = 1'b1; coreRst = 1'b0; modePin = mode; applyAndStep();
    for (int i = 0; i < 3; i++) begin cycle(); applyAndStep(); end
    cycle();
    porRst = 1'b0; applyAndStep();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset state (R10, R5) with mode latch open
    porRst = 1'b1; modePin = 1'b0;
    @(posedge clk); stepModel();
    for (int i = 0; i < 3; i++) begin cycle(); applyAndStep(); end
    cycle(); porRst = 1'b0; applyAndStep();

    // directed multiplexed frames: fetch then write, latchOff set (no effect, R6)
    latchOff = 1'b1;
    for (int i = 0; i < 24; i++) begin
      cycle();
      fetchReq = (i < 8); fetchAddr = 16'hBEEF; wrData = 8'h5A; portIn = 8'hC3;
      modePin = 1'b1;
      applyAndStep();
    end
    latchOff = 1'b0;
    randomRun(3000, 1'b1);

    // demultiplexed mode, parked and free-running strobe
    powerOn(1'b1);
    latchOff = 1'b1;
    for (int i = 0; i < 16; i++) begin
      cycle(); modePin = 1'b0; fetchReq = 1'b1; portIn = 8'h81; applyAndStep();
    end
    latchOff = 1'b0;
    randomRun(3000, 1'b1);

    // back to multiplexed, core reset must not reopen the mode latch (R2)
    powerOn(1'b0);
    cycle(); coreRst = 1'b1; modePin = 1'b1; applyAndStep();
    cycle(); coreRst = 1'b0; applyAndStep();
    randomRun(2000, 1'b0);

    cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule